// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Cache

This unit sits in the fetch stage of an in-order pipeline and owns the fetch program counter. Each cycle it looks up the current fetch address in two small direct-mapped tables, both indexed by the word-address bits just above the byte offset. The first table holds one 2-bit saturating direction counter per slot. The second table caches branch targets, with a valid bit and an address tag in each slot. The lookup reports whether the cache hit, which direction the counter predicts, and the predicted target. The next-address logic then steers fetch to the cached target with no bubble when a cached entry is predicted taken. In every other case it steps to the sequential address.

A later stage that resolves branches reports back through an update port. That port carries the branch address, the real direction, the real target and a flag that says the earlier guess was wrong. Every report trains the direction counter. A taken report also writes the target cache. A wrong guess raises a flush strobe in the same cycle and forces the next fetch address to the correct path. The flush action itself and the instruction memory are outside this block.

Top module: `bpred_unit`

## Requirements
- R1: While reset is applied, fetch_pc equals RESET_PC (default 0), pred_hit is 0 and pred_taken is 0. Every direction counter resets to 2'b01 and every target-cache slot resets invalid.
- R2: The slot index is fetch_pc[IDX_W+1:2]. pred_taken is bit 1 of the counter in that slot, so 2'b00 and 2'b01 predict not taken and 2'b10 and 2'b11 predict taken.
- R3: Each update with upd_valid=1 changes the counter at upd_pc[IDX_W+1:2]. A taken outcome adds one, saturating at 2'b11. A not-taken outcome subtracts one, saturating at 2'b00. From a saturated state, the predicted direction changes only after two opposite outcomes in a row.
- R4: pred_hit is 1 when the slot is valid and its stored tag equals fetch_pc[PC_W-1:IDX_W+2]. pred_target is the stored target on a hit and fetch_pc+4 otherwise.
- R5: An update with upd_valid=1 and upd_taken=1 writes the target-cache slot: valid is set, the tag comes from upd_pc and the target from upd_target. A not-taken update leaves the target cache unchanged.
- R6: When there is no flush, the next fetch_pc is pred_target if pred_hit and pred_taken are both 1, and fetch_pc+4 otherwise. A redirect to the cached target costs no extra cycle.
- R7: When upd_valid and upd_mispredict are both 1, flush is 1 in that same cycle. The next fetch_pc is then upd_target if upd_taken is 1, and upd_pc+4 if it is 0. This overrides the prediction.
- R8: If a lookup and an update touch the same slot in one cycle, the lookup returns the contents from before the update. The new contents are visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |
| upd_target | input | PC_W | Real target of the resolved branch |
| upd_mispredict | input | 1 | The earlier prediction for this branch was wrong |
| fetch_pc | output | PC_W | Current fetch address |
| pred_hit | output | 1 | The target cache holds an entry for fetch_pc |
| pred_taken | output | 1 | The direction counter predicts taken |
| pred_target | output | PC_W | Predicted next address for a taken branch |
| flush | output | 1 | A wrong guess was reported; discard the younger instructions |

## Verification
A steady sequential walk checks that fetch advances by four when the cache misses. A trained branch that is fetched again checks that a hit predicted taken jumps straight to its target. Alternating taken and not-taken reports on one branch, pushed to both saturation limits, separate a 2-bit counter from a 1-bit flag: one contrary outcome must not flip a strong state. An aliased address that shares a slot but has a different tag confirms that the tag is compared. An update made while that same slot is being fetched checks that the old contents are returned in that cycle. Wrong-guess reports on both the taken and the not-taken path check the flush strobe and the forced fetch address.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WEAK_NT;

  // Saturating step of a direction counter toward the observed outcome.
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e res;
    res = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) res = ctr_e'(cur + 2'b01);
    end else begin
      if (cur != CTR_STRONG_NT) res = ctr_e'(cur - 2'b01);
    end
    return res;
  endfunction

  function automatic logic ctr_predicts_taken(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
  import bpred_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_e ctr_q [DEPTH];
  ctr_e ctr_d [DEPTH];
  logic ctr_en [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_comb begin
        ctr_en[gi] = wr_en && (wr_idx == IDX_W'(gi));
        ctr_d[gi]  = ctr_step(ctr_q[gi], wr_taken);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctr_q[gi] <= CTR_RESET;
        end else if (ctr_en[gi]) begin
          ctr_q[gi] <= ctr_d[gi];
        end
      end
    end
  endgenerate

  // Read returns the registered value: a same-cycle write is seen next cycle.
  assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/bpred_target_cache.sv
module bpred_target_cache #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int LSB   = 2;
  localparam int TAG_W = PC_W - IDX_W - LSB;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [DEPTH-1:0] slot_en;

  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;

  assign rd_idx = rd_pc[IDX_W+LSB-1:LSB];
  assign rd_tag = rd_pc[PC_W-1:IDX_W+LSB];
  assign wr_idx = wr_pc[IDX_W+LSB-1:LSB];
  assign wr_tag = wr_pc[PC_W-1:IDX_W+LSB];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      assign slot_en[gi] = wr_en && (wr_idx == IDX_W'(gi));

      // Valid bit needs reset; tag and target are qualified by it.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[gi] <= 1'b0;
        end else if (slot_en[gi]) begin
          vld_q[gi] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (slot_en[gi]) begin
          tag_q[gi] <= wr_tag;
          tgt_q[gi] <= wr_target;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_target = tgt_q[rd_idx];
  end

endmodule

// File: rtl/bpred_next_pc.sv
module bpred_next_pc #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pred_hit,
  input  logic            pred_taken,
  input  logic [PC_W-1:0] pred_target,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    if (redirect) begin
      pc_d = redirect_pc;
    end else if (pred_hit && pred_taken) begin
      pc_d = pred_target;
    end else begin
      pc_d = pc_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/bpred_unit.sv
module bpred_unit
  import bpred_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              IDX_W    = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_mispredict,
  output logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic            flush
);

  localparam int              LSB  = 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [IDX_W-1:0] look_idx;
  logic [IDX_W-1:0] upd_idx;
  ctr_e             look_ctr;
  logic             cache_hit;
  logic [PC_W-1:0]  cache_tgt;
  logic             redirect;
  logic [PC_W-1:0]  redirect_pc;

  assign look_idx = fetch_pc[IDX_W+LSB-1:LSB];
  assign upd_idx  = upd_pc[IDX_W+LSB-1:LSB];

  bpred_dir_table #(
    .IDX_W (IDX_W)
  ) u_dir (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (look_idx),
    .rd_ctr   (look_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  bpred_target_cache #(
    .PC_W  (PC_W),
    .IDX_W (IDX_W)
  ) u_cache (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_pc     (fetch_pc),
    .rd_hit    (cache_hit),
    .rd_target (cache_tgt),
    .wr_en     (upd_valid && upd_taken),
    .wr_pc     (upd_pc),
    .wr_target (upd_target)
  );

  always_comb begin
    redirect    = upd_valid && upd_mispredict;
    redirect_pc = upd_taken ? upd_target : (upd_pc + STEP);
  end

  bpred_next_pc #(
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
  ) u_npc (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .pc          (fetch_pc)
  );

  always_comb begin
    pred_hit    = cache_hit;
    pred_taken  = ctr_predicts_taken(look_ctr);
    pred_target = cache_hit ? cache_tgt : (fetch_pc + STEP);
    flush       = redirect;
  end

endmodule

// File: rtl/bpred_unit_checker.sv
module bpred_unit_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_mispredict,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic            flush
);

  // R6: a cached taken prediction is followed the very next cycle
  p_take_cached_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flush && pred_hit && pred_taken) |=> (fetch_pc == $past(pred_target)));

  // R6: otherwise fetch steps by one word
  p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flush && !(pred_hit && pred_taken)) |=> (fetch_pc == $past(fetch_pc) + PC_W'(4)));

  // R7: a wrong guess on a taken branch forces its target
  p_fix_taken_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_valid && upd_mispredict && upd_taken) |=> (fetch_pc == $past(upd_target)));

  // R7: a wrong guess on a not-taken branch forces its fall-through
  p_fix_nt_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_valid && upd_mispredict && !upd_taken) |=> (fetch_pc == $past(upd_pc) + PC_W'(4)));

  // R4: a miss offers the sequential address as target
  p_miss_target_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !pred_hit |-> (pred_target == fetch_pc + PC_W'(4)));

  // R7: no flush without a reported wrong guess
  p_flush_src_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |-> (upd_valid && upd_mispredict));

endmodule

bind bpred_unit bpred_unit_checker #(.PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_ni         (rst_sync_n),
  .upd_valid      (upd_valid),
  .upd_pc         (upd_pc),
  .upd_taken      (upd_taken),
  .upd_target     (upd_target),
  .upd_mispredict (upd_mispredict),
  .fetch_pc       (fetch_pc),
  .pred_hit       (pred_hit),
  .pred_taken     (pred_taken),
  .pred_target    (pred_target),
  .flush          (flush)
);

// File: tb/bpred_unit_bench.sv
module bpred_unit_bench;

  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk;
  logic            rst_n;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;
  logic [PC_W-1:0] upd_target;
  logic            upd_mispredict;
  logic [PC_W-1:0] fetch_pc;
  logic            pred_hit;
  logic            pred_taken;
  logic [PC_W-1:0] pred_target;
  logic            flush;

  bpred_unit u_bpred_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_target     (upd_target),
    .upd_mispredict (upd_mispredict),
    .fetch_pc       (fetch_pc),
    .pred_hit       (pred_hit),
    .pred_taken     (pred_taken),
    .pred_target    (pred_target),
    .flush          (flush)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks;
  int errors;
  bit done;

  typedef struct {
    logic [PC_W-1:0] pc;
    logic            hit;
    logic            taken;
    logic [PC_W-1:0] target;
    logic            flush;
    bit              full;
    string           req;
  } exp_t;

  exp_t exp_q[$];

  // Reference model state, written from the requirements.
  logic [PC_W-1:0] m_pc;
  logic [1:0]      m_ctr [DEPTH];
  logic            m_vld [DEPTH];
  logic [PC_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0] m_tgt [DEPTH];

  function automatic int idx_of(logic [PC_W-1:0] a);
    return int'((a >> 2) & (DEPTH - 1));
  endfunction

  task automatic model_reset();
    m_pc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_ctr[i] = 2'b01;
      m_vld[i] = 1'b0;
      m_tag[i] = '0;
      m_tgt[i] = '0;
    end
  endtask

  task automatic check(bit ok, string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(bit v, logic [PC_W-1:0] upc, bit tk, logic [PC_W-1:0] tgt, bit mis,
                      string req, bit full = 1'b1);
    exp_t e;
    int   li;
    int   ui;
    @(negedge clk);
    upd_valid      = v;
    upd_pc         = upc;
    upd_taken      = tk;
    upd_target     = tgt;
    upd_mispredict = mis;
    li       = idx_of(m_pc);
    e.pc     = m_pc;
    e.hit    = m_vld[li] && (m_tag[li] == (m_pc >> (IDX_W + 2)));
    e.taken  = m_ctr[li][1];
    e.target = e.hit ? m_tgt[li] : m_pc + 4;
    e.flush  = v && mis;
    e.full   = full;
    e.req    = req;
    exp_q.push_back(e);
    // Advance the model as the clock edge will.
    if (e.flush)                m_pc = tk ? tgt : upc + 4;
    else if (e.hit && e.taken)  m_pc = e.target;
    else                        m_pc = m_pc + 4;
    if (v) begin
      ui = idx_of(upc);
      if (tk && m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'b01;
      if (!tk && m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'b01;
      if (tk) begin
        m_vld[ui] = 1'b1;
        m_tag[ui] = upc >> (IDX_W + 2);
        m_tgt[ui] = tgt;
      end
    end
  endtask

  task automatic idle(string req);
    step(1'b0, '0, 1'b0, '0, 1'b0, req);
  endtask

  // Steer fetch to an address through a wrong-guess report on a spare slot-0 branch.
  task automatic go_to(logic [PC_W-1:0] dst, string req);
    step(1'b1, 32'h0000_0F00, 1'b1, dst, 1'b1, req);
  endtask

  // Monitor: pops one expected item per cycle and compares mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(flush == e.flush, e.req, "flush", PC_W'(flush), PC_W'(e.flush));
        if (e.full) begin
          check(fetch_pc == e.pc, e.req, "fetch_pc", fetch_pc, e.pc);
          check(pred_hit == e.hit, e.req, "pred_hit", PC_W'(pred_hit), PC_W'(e.hit));
          check(pred_taken == e.taken, e.req, "pred_taken", PC_W'(pred_taken), PC_W'(e.taken));
          check(pred_target == e.target, e.req, "pred_target", pred_target, e.target);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n          = 1'b0;
    upd_valid      = 1'b0;
    upd_pc         = '0;
    upd_taken      = 1'b0;
    upd_target     = '0;
    upd_mispredict = 1'b0;
    model_reset();
    @(negedge clk);
    #2;
    check(fetch_pc == '0, "R1", "fetch_pc in reset", fetch_pc, '0);
    check(pred_hit == 1'b0, "R1", "pred_hit in reset", PC_W'(pred_hit), '0);
    check(pred_taken == 1'b0, "R1", "pred_taken in reset", PC_W'(pred_taken), '0);
    check(flush == 1'b0, "R1", "flush in reset", PC_W'(flush), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // First redirect: fetch position is not yet tracked, only flush is compared.
    step(1'b1, 32'h0000_0F00, 1'b1, 32'h0, 1'b1, "R7", 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b1;
    do_reset();

    // R6: sequential walk on misses, R1 counters weakly not taken (R2)
    repeat (4) idle("R6");
    // Now at 0x10: train it taken while it is being fetched (R8, R5, R3)
    step(1'b1, 32'h10, 1'b1, 32'h100, 1'b0, "R8");
    idle("R8");
    // Back to 0x10: hit, counter 10 predicts taken, jump with no bubble (R4, R2, R6)
    go_to(32'h10, "R7");
    idle("R6");
    idle("R4");
    // Strengthen to 11, then one not-taken: still taken (R3)
    step(1'b1, 32'h10, 1'b1, 32'h100, 1'b0, "R3");
    step(1'b1, 32'h10, 1'b0, 32'h0, 1'b1, "R7");
    go_to(32'h10, "R7");
    idle("R3");
    // Second not-taken flips to 01: hit but not taken, sequential (R3, R6)
    step(1'b1, 32'h10, 1'b0, 32'h0, 1'b0, "R3");
    go_to(32'h10, "R7");
    idle("R3");
    // Aliased address 0x50 shares slot 4 but misses on the tag (R4)
    go_to(32'h50, "R7");
    idle("R4");
    // Not-taken wrong guess on 0x24 must not allocate (R5, R7)
    step(1'b1, 32'h24, 1'b0, 32'h400, 1'b1, "R5");
    go_to(32'h24, "R7");
    idle("R5");
    // Saturate down to 00, then one taken stays not taken (R3)
    repeat (3) step(1'b1, 32'h10, 1'b0, 32'h0, 1'b0, "R3");
    step(1'b1, 32'h10, 1'b1, 32'h200, 1'b0, "R3");
    go_to(32'h10, "R7");
    idle("R3");
    step(1'b1, 32'h10, 1'b1, 32'h200, 1'b0, "R3");
    go_to(32'h10, "R7");
    idle("R2");
    idle("R6");
    // Same-slot update while fetching a hit: old target returned this cycle (R8)
    go_to(32'h10, "R7");
    step(1'b1, 32'h10, 1'b1, 32'h300, 1'b0, "R8");
    go_to(32'h10, "R7");
    idle("R8");
    idle("R6");

    // Reset mid-run clears everything (R1)
    do_reset();
    go_to(32'h10, "R7");
    idle("R1");
    idle("R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule